// File: doc/BRIEF.md
# Repeated-Subtraction Rounding Divider

This block divides an unsigned numerator by an unsigned denominator. Both operands are run-time values. It takes the operands on a start pulse. It then subtracts the denominator from a working remainder once per clock and counts each subtraction. When the working remainder falls below the denominator, the count is the quotient and the leftover is the remainder. When rounding is enabled, the quotient is bumped up by one if the leftover is at least half of the denominator. Because the loop runs once per unit of quotient, latency depends on the data.

A controller with two named states drives the loop. `ST_IDLE` waits for a start. Its transitions are:
- An accepted start with a non-zero denominator goes to `ST_SUBTRACT` (transition *accept*).
- An accepted start with a zero denominator finishes at once and stays in `ST_IDLE` (transition *zero-finish*).

`ST_SUBTRACT` has two transitions:
- While the working value is at least the denominator, it stays in `ST_SUBTRACT` (transition *step*).
- Otherwise it writes the result, pulses `done` and returns to `ST_IDLE` (transition *finish*).

Results are registered and held between completions.

Top module: `subloop_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: With `round_en` low and a non-zero denominator D, the result is `quotient` = floor(N/D) and `remainder` = N mod D.
- R3: With `round_en` high and D non-zero, `quotient` is floor(N/D)+1 when 2·(N mod D) ≥ D, and floor(N/D) otherwise. The tie 2·rem = D rounds up. `remainder` is still N mod D.
- R4: For a non-zero D, `done` is seen floor(N/D)+2 clock edges after the accepting edge, counting that edge as 1.
- R5: A numerator below the denominator performs no subtraction. `done` comes at edge 2, and `quotient` is 0, or 1 if rounding applies.
- R6: A zero denominator produces `done` at the accepting edge, with `div_by_zero` = 1, `quotient` = 16'hFFFF and `remainder` = N, whatever `round_en` is.
- R7: `busy` is high from the accepting edge up to the finishing edge. `done` is a one-cycle pulse, and `busy` is low while `done` is high.
- R8: A start while `busy` is high is ignored. Operand inputs are sampled only at the accepting edge, so changing them during the loop has no effect on the result or its timing.
- R9: `quotient`, `remainder` and `div_by_zero` hold their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, accepted only while not busy |
| round_en | input | 1 | Enables round-to-nearest on the quotient |
| numerator | input | 16 | Unsigned dividend |
| denominator | input | 16 | Unsigned divisor |
| busy | output | 1 | Subtraction loop running |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 16 | Result count, optionally rounded |
| remainder | output | 16 | Leftover after the last subtraction |
| div_by_zero | output | 1 | Set when the denominator was zero |

## Verification
Every result is due a fixed number of edges after the accepting edge:
- one edge for a zero denominator;
- floor(N/D)+2 edges otherwise, with floor(N/D)+1 of them spent busy.

The bench counts edges from the accepting edge and samples `done`, `busy` and the results at the falling edge after each rising edge. It compares the edge count at which `done` first appears with the expected value, so one cycle early or late is reported. The checker keeps its own copy of the accepted operands and a cycle counter, and uses them to relate the latency and the reconstructed N = q·D + r to each `done`.

// File: rtl/subdiv_pkg.sv
package subdiv_pkg;

    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_SUBTRACT = 1'b1
    } div_state_t;

endpackage

// File: rtl/subdiv_datapath.sv
// Working remainder, subtraction counter and the operand copies taken at
// the accepting edge.
module subdiv_datapath #(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [W-1:0]  num_in,
    input  logic [W-1:0]  den_in,
    input  logic          rnd_in,
    output logic [W-1:0]  work_o,
    output logic [CW-1:0] count_o,
    output logic [W-1:0]  den_o,
    output logic          rnd_o,
    output logic          ge_o
);

    logic [W-1:0]  work_q;
    logic [CW-1:0] count_q;
    logic [W-1:0]  den_q;
    logic          rnd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q  <= '0;
            count_q <= '0;
            den_q   <= '0;
            rnd_q   <= 1'b0;
        end else if (load) begin
            work_q  <= num_in;
            count_q <= '0;
            den_q   <= den_in;
            rnd_q   <= rnd_in;
        end else if (step) begin
            work_q  <= work_q - den_q;
            count_q <= count_q + 1'b1;
        end
    end

    assign ge_o    = (work_q >= den_q);
    assign work_o  = work_q;
    assign count_o = count_q;
    assign den_o   = den_q;
    assign rnd_o   = rnd_q;

endmodule

// File: rtl/subdiv_rounder.sv
// Round-half-up on the count: add one when twice the leftover reaches the divisor.
module subdiv_rounder #(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic [CW-1:0] count_i,
    input  logic [W-1:0]  rem_i,
    input  logic [W-1:0]  den_i,
    input  logic          en_i,
    output logic [CW-1:0] quot_o
);

    localparam int DW = W + 1;

    logic [DW-1:0] rem_x2;
    logic [DW-1:0] den_x;
    logic          bump;

    always_comb begin
        rem_x2 = {rem_i, 1'b0};
        den_x  = {1'b0, den_i};
        bump   = en_i && (rem_x2 >= den_x);
        quot_o = bump ? count_i + 1'b1 : count_i;
    end

endmodule

// File: rtl/subdiv_ctrl.sv
// Two-state controller: state register, next-state logic, registered outputs.
module subdiv_ctrl
    import subdiv_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  num_in,
    input  logic [W-1:0]  den_in,
    input  logic          ge,
    input  logic [W-1:0]  work,
    input  logic [CW-1:0] rounded_q,
    output logic          load,
    output logic          step,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] quotient,
    output logic [W-1:0]  remainder,
    output logic          div_by_zero
);

    localparam logic [CW-1:0] Q_SATURATE = {CW{1'b1}};

    div_state_t state_q, state_d;
    logic       accept;
    logic       den_zero;
    logic       finish;

    assign accept   = start && (state_q == ST_IDLE);
    assign den_zero = (den_in == '0);
    assign finish   = (state_q == ST_SUBTRACT) && !ge;
    assign load     = accept && !den_zero;
    assign step     = (state_q == ST_SUBTRACT) && ge;
    assign busy     = (state_q == ST_SUBTRACT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (load)   state_d = ST_SUBTRACT;
            ST_SUBTRACT: if (finish) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && den_zero) begin
                        done        <= 1'b1;
                        quotient    <= Q_SATURATE;
                        remainder   <= num_in;
                        div_by_zero <= 1'b1;
                    end
                end
                ST_SUBTRACT: begin
                    if (finish) begin
                        done        <= 1'b1;
                        quotient    <= rounded_q;
                        remainder   <= work;
                        div_by_zero <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/subloop_divider.sv
module subloop_divider #(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          round_en,
    input  logic [W-1:0]  numerator,
    input  logic [W-1:0]  denominator,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] quotient,
    output logic [W-1:0]  remainder,
    output logic          div_by_zero
);

    logic          load, step, ge, rnd_l;
    logic [W-1:0]  work, den_l;
    logic [CW-1:0] count, rounded_q;

    subdiv_datapath #(.W(W), .CW(CW)) dp_i (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .num_in(numerator), .den_in(denominator), .rnd_in(round_en),
        .work_o(work), .count_o(count), .den_o(den_l), .rnd_o(rnd_l),
        .ge_o(ge)
    );

    subdiv_rounder #(.W(W), .CW(CW)) rnd_i (
        .count_i(count), .rem_i(work), .den_i(den_l), .en_i(rnd_l),
        .quot_o(rounded_q)
    );

    subdiv_ctrl #(.W(W), .CW(CW)) ctl_i (
        .clk(clk), .rst(rst), .start(start),
        .num_in(numerator), .den_in(denominator),
        .ge(ge), .work(work), .rounded_q(rounded_q),
        .load(load), .step(step), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .div_by_zero(div_by_zero)
    );

endmodule

// File: rtl/subloop_divider_chk.sv
module subloop_divider_chk #(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          round_en,
    input logic [W-1:0]  numerator,
    input logic [W-1:0]  denominator,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] quotient,
    input logic [W-1:0]  remainder,
    input logic          div_by_zero
);

    logic        acc;
    logic [31:0] n_l, d_l, cyc;
    logic        r_l;
    logic [31:0] q32, r32, exact, bumped;
    logic        rounds;

    assign acc = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_l <= '0; d_l <= '0; r_l <= 1'b0; cyc <= '0;
        end else if (acc) begin
            n_l <= 32'(numerator);
            d_l <= 32'(denominator);
            r_l <= round_en;
            cyc <= 32'd1;
        end else if (cyc != 0) begin
            cyc <= cyc + 32'd1;
        end
    end

    always_comb begin
        q32    = 32'(quotient);
        r32    = 32'(remainder);
        rounds = r_l && ((r32 << 1) >= d_l);
        exact  = q32 * d_l + r32;
        bumped = (q32 - 32'd1) * d_l + r32;
    end

    a_r2_reconstruct: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> ((rounds ? bumped : exact) == n_l));
    a_r2_rem_below_den: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (r32 < d_l));
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (cyc == (n_l / d_l) + 32'd2));
    a_r6_zero_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (acc && denominator == '0) |=> (done && div_by_zero && quotient == '1));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_not_busy_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (acc && denominator != '0) |=> busy);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

bind subloop_divider subloop_divider_chk #(.W(W), .CW(CW)) chk_i (.*);

// File: tb/subloop_divider_tb_top.sv
`timescale 1ns/1ps
module subloop_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        round_en = 1'b0;
    logic [15:0] numerator = '0;
    logic [15:0] denominator = '0;
    logic        busy, done, div_by_zero;
    logic [15:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    subloop_divider dut_i (
        .clk(clk), .rst(rst), .start(start), .round_en(round_en),
        .numerator(numerator), .denominator(denominator),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .div_by_zero(div_by_zero)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one request; returns edges to done (accepting edge = 1) and busy edges.
    task automatic run_div(input int n, input int d, input bit en,
                           output int lat, output int busy_cnt);
        @(negedge clk);
        numerator = 16'(n); denominator = 16'(d); round_en = en; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 1; busy_cnt = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            if (busy) busy_cnt++;
            @(posedge clk);
            lat++;
            if (lat > 70000) break;
        end
    endtask

    task automatic expect_div(input string tag, input int n, input int d, input bit en);
        int lat, bc, q, r;
        run_div(n, d, en, lat, bc);
        q = n / d; r = n % d;
        chk({tag, " R4 latency"}, lat, q + 2);
        if (en && (2 * r >= d)) q++;
        chk({tag, en ? " R3 quotient" : " R2 quotient"}, quotient, q);
        chk({tag, " R2 remainder"}, remainder, r);
        chk({tag, " R7 busy edges"}, bc, n / d + 1);
        chk({tag, " R7 busy low at done"}, busy, 0);
        chk({tag, " R6 flag clear"}, div_by_zero, 0);
        @(negedge clk);
        chk({tag, " R7 done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 dbz", div_by_zero, 0);
        chk("R1 quotient", quotient, 0);
        chk("R1 remainder", remainder, 0);
    endtask

    task automatic t_basic();
        expect_div("R2 100/7", 100, 7, 0);
        expect_div("R2 12345/123", 12345, 123, 0);
        expect_div("R2 n=d", 500, 500, 0);
        expect_div("R2 exact 96/8", 96, 8, 0);
    endtask

    task automatic t_round();
        expect_div("R3 tie 7/2", 7, 2, 1);
        expect_div("R3 tie 10/4", 10, 4, 1);
        expect_div("R3 below 10/3", 10, 3, 1);
        expect_div("R3 above 11/3", 11, 3, 1);
        expect_div("R3 exact 96/8", 96, 8, 1);
    endtask

    task automatic t_small();
        expect_div("R5 3/10 norm", 3, 10, 0);
        expect_div("R5 3/10 rnd", 3, 10, 1);
        expect_div("R5 5/10 rnd", 5, 10, 1);
        expect_div("R5 0/9 rnd", 0, 9, 1);
    endtask

    task automatic t_zero();
        int lat, bc;
        run_div(1234, 0, 1'b1, lat, bc);
        chk("R6 latency", lat, 1);
        chk("R6 flag", div_by_zero, 1);
        chk("R6 quotient", quotient, 16'hFFFF);
        chk("R6 remainder", remainder, 1234);
        chk("R6 busy never", bc, 0);
        run_div(77, 0, 1'b0, lat, bc);
        chk("R6 remainder2", remainder, 77);
        chk("R6 quotient2", quotient, 16'hFFFF);
        expect_div("R6 flag clears next", 9, 4, 0);
    endtask

    task automatic t_busy_ignore();
        int lat;
        @(negedge clk);
        numerator = 16'd100; denominator = 16'd3; round_en = 1'b0; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 1;
        repeat (4) begin @(posedge clk); lat++; end
        #1;
        numerator = 16'd9; denominator = 16'd0; round_en = 1'b1; start = 1'b1;
        @(posedge clk);
        lat++;
        #1 start = 1'b0;
        forever begin
            @(negedge clk);
            if (done || lat > 200) break;
            @(posedge clk);
            lat++;
        end
        chk("R8 latency unchanged", lat, 35);
        chk("R8 quotient", quotient, 33);
        chk("R8 remainder", remainder, 1);
        chk("R8 no dbz", div_by_zero, 0);
    endtask

    task automatic t_hold();
        int lat, bc;
        run_div(50, 6, 1'b0, lat, bc);
        numerator = 16'd1; denominator = 16'd0; round_en = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9 quotient held", quotient, 8);
        chk("R9 remainder held", remainder, 2);
        chk("R9 flag held", div_by_zero, 0);
        chk("R9 done low", done, 0);
    endtask

    task automatic t_big();
        expect_div("R4 65535/1", 65535, 1, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_round();
        t_small();
        t_zero();
        t_busy_ignore();
        t_hold();
        t_big();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule